// File: doc/BRIEF.md
# Directory Coherence Controller with Sharer Tracking

This block is a coherence directory placed next to main memory. For every address it serves it records which processors hold a cached copy and which processor, if any, holds the exclusive write lock. Processors send it requests (lock, fill, release, drop, lock-status check, flush). Each request gets one response back. The directory also keeps the memory words themselves, so fills and lock grants return the current data.

A lock request for an address that other processors hold sends out one invalidation message. The message carries a bit mask of the processors that must give up their copy. When that set holds more processors than a configurable limit, the message is also flagged as a broadcast. The directory then waits until every targeted processor has acknowledged. An acknowledgement that carries dirty data is written to memory before the lock is granted. Only one transaction is in flight at a time, and new requests wait while acknowledgements are outstanding. There is no copying from one cache to another, so the sharer record changes only through fills, drops, releases and lock grants.

Top module: `dir_coh_ctrl`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and inv_valid are 0, every address is uncached, and memory reads as zero.
- R2: A check request (op 4) is answered one cycle after acceptance with no invalidation: code 3 (held) if the address is locked, otherwise code 2 (free).
- R3: A fill (op 1) is refused (code 1) while a processor other than the requester holds the lock. Otherwise it is granted (code 0) with the memory word, and the requester becomes a sharer.
- R4: A lock (op 0) sends one invalidation whose mask (bit i = processor i) lists exactly the recorded holders other than the requester. After all of them have acknowledged, the lock is granted (code 0) with the memory word. A locked address has its owner as its only sharer.
- R5: The invalidation carries inv_bcast = 1 exactly when more than BCAST_LIMIT processors are targeted.
- R6: An acknowledgement with ack_dirty = 1 writes ack_data into memory before the grant. A clean acknowledgement leaves memory unchanged.
- R7: Acknowledgements from processors that are not awaited, or that arrive while nothing is awaited, have no effect.
- R8: From the invalidation until the grant, req_ready is 0.
- R9: A release (op 2) is granted only to the lock owner reporting req_dirty = 0. The address then becomes shared with the owner as its only sharer. Any other release is refused.
- R10: A flush (op 5) from the lock owner writes req_data to memory and is granted. A flush from any other processor is refused and leaves memory unchanged.
- R11: A drop (op 3) removes the requester from the sharers and is granted; the last drop leaves the address uncached. A drop from the lock owner is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_op | input | 3 | Request kind (0 lock, 1 fill, 2 release, 3 drop, 4 check, 5 flush) |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_addr | input | $clog2(NADDR) | Address of the request |
| req_dirty | input | 1 | Requester reports its copy dirty (release) |
| req_data | input | DW | Data written by a flush |
| resp_valid | output | 1 | Response pulse |
| resp_dst | output | $clog2(NPROC) | Processor the response is for |
| resp_code | output | 2 | 0 grant, 1 refuse, 2 free, 3 held |
| resp_data | output | DW | Memory word for fill and lock grants, else 0 |
| inv_valid | output | 1 | Invalidation pulse |
| inv_bcast | output | 1 | Invalidation sent as broadcast |
| inv_mask | output | NPROC | Processors that must give up their copy |
| inv_addr | output | $clog2(NADDR) | Address being invalidated |
| ack_valid | input | 1 | Invalidation acknowledgement present |
| ack_src | input | $clog2(NPROC) | Acknowledging processor |
| ack_dirty | input | 1 | Acknowledgement carries dirty data |
| ack_data | input | DW | Written-back data |

## Verification
The bench targets the lock that displaces a dirty owner. A design that skipped the write-back, or granted before the last acknowledgement, would return stale data with the grant. It sends a stray dirty acknowledgement from the requester during each invalidation and others while idle. A design that accepted unawaited acknowledgements would corrupt memory, and later fills would show it. It hits the broadcast limit from both sides, with three and with two targets. It also covers a release with a dirty copy, a flush or drop from a non-owner, and a fill against a foreign lock. Each of these would show up as a wrong response code or as a later wrong invalidation mask, for example an extra sharer left behind a lock.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
  localparam logic [2:0] OP_LOCK    = 3'd0;
  localparam logic [2:0] OP_FILL    = 3'd1;
  localparam logic [2:0] OP_RELEASE = 3'd2;
  localparam logic [2:0] OP_DROP    = 3'd3;
  localparam logic [2:0] OP_CHECK   = 3'd4;
  localparam logic [2:0] OP_FLUSH   = 3'd5;

  localparam logic [1:0] RC_GRANT  = 2'd0;
  localparam logic [1:0] RC_REFUSE = 2'd1;
  localparam logic [1:0] RC_FREE   = 2'd2;
  localparam logic [1:0] RC_HELD   = 2'd3;

  typedef enum logic [1:0] {LN_UNC, LN_SHR, LN_LCK} ln_e;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RD, S_RSP} fsm_e;
endpackage

// File: rtl/coh_data_ram.sv
`timescale 1ns/1ps
module coh_data_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/coh_dir_table.sv
`timescale 1ns/1ps
module coh_dir_table
  import coh_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NADDR = 8,
  localparam int SW   = $clog2(NPROC),
  localparam int AW   = $clog2(NADDR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    raddr,
  output ln_e              rd_st,
  output logic [SW-1:0]    rd_own,
  output logic [NPROC-1:0] rd_shr,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  ln_e              w_st,
  input  logic [SW-1:0]    w_own,
  input  logic [NPROC-1:0] w_shr
);
  localparam logic [NPROC-1:0] ONE = {{(NPROC-1){1'b0}}, 1'b1};

  ln_e              st_q  [NADDR];
  logic [SW-1:0]    own_q [NADDR];
  logic [NPROC-1:0] shr_q [NADDR];

  for (genvar g = 0; g < NADDR; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g]  <= LN_UNC;
        own_q[g] <= '0;
        shr_q[g] <= '0;
      end else if (we && (waddr == AW'(g))) begin
        st_q[g]  <= w_st;
        own_q[g] <= w_own;
        shr_q[g] <= w_shr;
      end
    end

    // R4
    lock_sole_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q[g] == LN_LCK) |-> (shr_q[g] == (ONE << own_q[g])));

    // R11
    uncached_empty_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q[g] == LN_UNC) |-> (shr_q[g] == '0));

    // R3
    shared_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q[g] == LN_SHR) |-> (shr_q[g] != '0));
  end

  assign rd_st  = st_q[raddr];
  assign rd_own = own_q[raddr];
  assign rd_shr = shr_q[raddr];
endmodule

// File: rtl/coh_inv_gen.sv
`timescale 1ns/1ps
module coh_inv_gen #(
  parameter int NPROC = 4,
  parameter int LIMIT = 2,
  localparam int SW   = $clog2(NPROC),
  localparam int CW   = $clog2(NPROC + 1)
) (
  input  logic [NPROC-1:0] shr,
  input  logic [SW-1:0]    src,
  output logic [NPROC-1:0] tgt,
  output logic             over
);
  logic [CW-1:0] cnt;

  always_comb begin
    tgt      = shr;
    tgt[src] = 1'b0;
    cnt      = '0;
    for (int i = 0; i < NPROC; i++) cnt = cnt + CW'(tgt[i]);
  end

  assign over = (int'(cnt) > LIMIT);
endmodule

// File: rtl/dir_coh_ctrl.sv
`timescale 1ns/1ps
module dir_coh_ctrl
  import coh_pkg::*;
#(
  parameter int NPROC       = 4,
  parameter int NADDR       = 8,
  parameter int DW          = 16,
  parameter int BCAST_LIMIT = 2,
  localparam int SW         = $clog2(NPROC),
  localparam int AW         = $clog2(NADDR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [SW-1:0]    req_src,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_dirty,
  input  logic [DW-1:0]    req_data,
  output logic             resp_valid,
  output logic [SW-1:0]    resp_dst,
  output logic [1:0]       resp_code,
  output logic [DW-1:0]    resp_data,
  output logic             inv_valid,
  output logic             inv_bcast,
  output logic [NPROC-1:0] inv_mask,
  output logic [AW-1:0]    inv_addr,
  input  logic             ack_valid,
  input  logic [SW-1:0]    ack_src,
  input  logic             ack_dirty,
  input  logic [DW-1:0]    ack_data
);
  localparam logic [NPROC-1:0] ONE = {{(NPROC-1){1'b0}}, 1'b1};

  fsm_e             state_q, state_n;
  logic [2:0]       op_q;
  logic [SW-1:0]    src_q;
  logic [AW-1:0]    addr_q;
  logic [NPROC-1:0] pend_q, pend_n;

  // directory table ports
  logic [AW-1:0]    t_raddr;
  ln_e              t_st;
  logic [SW-1:0]    t_own;
  logic [NPROC-1:0] t_shr;
  logic             tw_en;
  logic [AW-1:0]    tw_addr;
  ln_e              tw_st;
  logic [SW-1:0]    tw_own;
  logic [NPROC-1:0] tw_shr;

  // memory ports
  logic             mw_en;
  logic [AW-1:0]    mw_addr;
  logic [DW-1:0]    mw_data;
  logic [DW-1:0]    ram_q;

  // invalidation targets
  logic [NPROC-1:0] tgt;
  logic             over;

  logic             accept, is_owner, rsp_go, rsp_use_ram, inv_go, lat_req;
  logic [1:0]       rsp_code;
  logic [NPROC-1:0] src_bit, cur_bit, ack_bit, drop_shr;

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign t_raddr   = (state_q == S_IDLE) ? req_addr : addr_q;
  assign src_bit   = ONE << req_src;
  assign cur_bit   = ONE << src_q;
  assign ack_bit   = ONE << ack_src;
  assign is_owner  = (t_st == LN_LCK) && (t_own == req_src);
  assign drop_shr  = t_shr & ~src_bit;

  coh_dir_table #(.NPROC(NPROC), .NADDR(NADDR)) u_table (
    .clk(clk), .rst(rst), .raddr(t_raddr),
    .rd_st(t_st), .rd_own(t_own), .rd_shr(t_shr),
    .we(tw_en), .waddr(tw_addr), .w_st(tw_st), .w_own(tw_own), .w_shr(tw_shr)
  );

  coh_data_ram #(.DW(DW), .DEPTH(NADDR)) u_ram (
    .clk(clk), .we(mw_en), .waddr(mw_addr), .wdata(mw_data),
    .raddr(addr_q), .rdata(ram_q)
  );

  coh_inv_gen #(.NPROC(NPROC), .LIMIT(BCAST_LIMIT)) u_inv (
    .shr(t_shr), .src(req_src), .tgt(tgt), .over(over)
  );

  always_comb begin
    state_n     = state_q;
    pend_n      = pend_q;
    tw_en       = 1'b0;
    tw_addr     = addr_q;
    tw_st       = t_st;
    tw_own      = t_own;
    tw_shr      = t_shr;
    mw_en       = 1'b0;
    mw_addr     = addr_q;
    mw_data     = ack_data;
    rsp_go      = 1'b0;
    rsp_code    = RC_GRANT;
    rsp_use_ram = 1'b0;
    inv_go      = 1'b0;
    lat_req     = 1'b0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        lat_req = 1'b1;
        case (req_op)
          OP_CHECK: begin
            rsp_go   = 1'b1;
            rsp_code = (t_st == LN_LCK) ? RC_HELD : RC_FREE;
          end
          OP_FILL: begin
            if (t_st == LN_LCK && t_own != req_src) begin
              rsp_go   = 1'b1;
              rsp_code = RC_REFUSE;
            end else begin
              state_n = S_RD;
            end
          end
          OP_LOCK: begin
            if (tgt != '0) begin
              inv_go  = 1'b1;
              pend_n  = tgt;
              state_n = S_WAIT;
            end else begin
              state_n = S_RD;
            end
          end
          OP_RELEASE: begin
            rsp_go = 1'b1;
            if (is_owner && !req_dirty) begin
              tw_en   = 1'b1;
              tw_addr = req_addr;
              tw_st   = LN_SHR;
              tw_shr  = src_bit;
            end else begin
              rsp_code = RC_REFUSE;
            end
          end
          OP_DROP: begin
            rsp_go = 1'b1;
            if (is_owner) begin
              rsp_code = RC_REFUSE;
            end else begin
              tw_en   = 1'b1;
              tw_addr = req_addr;
              tw_shr  = drop_shr;
              tw_st   = (drop_shr == '0) ? LN_UNC : t_st;
            end
          end
          OP_FLUSH: begin
            rsp_go = 1'b1;
            if (is_owner) begin
              mw_en   = 1'b1;
              mw_addr = req_addr;
              mw_data = req_data;
            end else begin
              rsp_code = RC_REFUSE;
            end
          end
          default: begin
            rsp_go   = 1'b1;
            rsp_code = RC_REFUSE;
          end
        endcase
      end
      S_WAIT: if (ack_valid && pend_q[ack_src]) begin
        pend_n = pend_q & ~ack_bit;
        mw_en  = ack_dirty;
        if ((pend_q & ~ack_bit) == '0) state_n = S_RD;
      end
      S_RD: state_n = S_RSP;
      S_RSP: begin
        rsp_go      = 1'b1;
        rsp_use_ram = 1'b1;
        state_n     = S_IDLE;
        tw_en       = 1'b1;
        if (op_q == OP_LOCK) begin
          tw_st  = LN_LCK;
          tw_own = src_q;
          tw_shr = cur_bit;
        end else begin
          tw_st  = (t_st == LN_LCK) ? LN_LCK : LN_SHR;
          tw_shr = t_shr | cur_bit;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      pend_q     <= '0;
      op_q       <= '0;
      src_q      <= '0;
      addr_q     <= '0;
      resp_valid <= 1'b0;
      resp_dst   <= '0;
      resp_code  <= '0;
      resp_data  <= '0;
      inv_valid  <= 1'b0;
      inv_bcast  <= 1'b0;
      inv_mask   <= '0;
      inv_addr   <= '0;
    end else begin
      state_q    <= state_n;
      pend_q     <= pend_n;
      resp_valid <= rsp_go;
      inv_valid  <= inv_go;
      if (lat_req) begin
        op_q   <= req_op;
        src_q  <= req_src;
        addr_q <= req_addr;
      end
      if (rsp_go) begin
        resp_code <= rsp_code;
        resp_dst  <= (state_q == S_IDLE) ? req_src : src_q;
        resp_data <= rsp_use_ram ? ram_q : '0;
      end
      if (inv_go) begin
        inv_mask  <= tgt;
        inv_bcast <= over;
        inv_addr  <= req_addr;
      end
    end
  end

  // R5
  bcast_wide_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_bcast) |-> ($countones(inv_mask) > BCAST_LIMIT));

  // R5
  bcast_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !inv_bcast) |-> ($countones(inv_mask) <= BCAST_LIMIT));

  // R4
  inv_excl_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> ((inv_mask != '0) && !inv_mask[src_q]));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !req_ready);

  // R7
  pend_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WAIT) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: tb/test_dir_coh_ctrl.sv
`timescale 1ns/1ps
module test_dir_coh_ctrl;
  localparam int NP = 4, NA = 8, DW = 16, LIM = 2;
  localparam int SW = $clog2(NP), AW = $clog2(NA);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          req_valid = 0, req_dirty = 0, ack_valid = 0, ack_dirty = 0;
  logic [2:0]    req_op = 0;
  logic [SW-1:0] req_src = 0, ack_src = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_data = 0, ack_data = 0;
  logic          req_ready, resp_valid, inv_valid, inv_bcast;
  logic [SW-1:0] resp_dst;
  logic [1:0]    resp_code;
  logic [DW-1:0] resp_data;
  logic [NP-1:0] inv_mask;
  logic [AW-1:0] inv_addr;

  dir_coh_ctrl #(.NPROC(NP), .NADDR(NA), .DW(DW), .BCAST_LIMIT(LIM)) i_dir_coh_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src(req_src), .req_addr(req_addr), .req_dirty(req_dirty),
    .req_data(req_data), .resp_valid(resp_valid), .resp_dst(resp_dst),
    .resp_code(resp_code), .resp_data(resp_data), .inv_valid(inv_valid),
    .inv_bcast(inv_bcast), .inv_mask(inv_mask), .inv_addr(inv_addr),
    .ack_valid(ack_valid), .ack_src(ack_src), .ack_dirty(ack_dirty), .ack_data(ack_data)
  );

  int n_tests = 0, n_fail = 0;

  // model: state 0 uncached, 1 shared, 2 locked
  int            m_st   [NA];
  int            m_own  [NA];
  logic [NP-1:0] m_shr  [NA];
  logic [DW-1:0] m_mem  [NA];
  bit            m_dirty[NA];
  logic [DW-1:0] m_loc  [NA];

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic int pc(input logic [NP-1:0] v);
    int c = 0;
    for (int i = 0; i < NP; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic xact(input int op, input int src, input int addr, input string rq);
    logic [NP-1:0] bit_s = NP'(1) << src;
    logic [NP-1:0] tgt = '0;
    bit is_own = (m_st[addr] == 2) && (m_own[addr] == src);
    bit dirty_in = is_own ? m_dirty[addr] : 1'b0;
    logic [DW-1:0] data_in = is_own ? m_loc[addr] : DW'($urandom);
    int exp_code = 1;
    logic [DW-1:0] exp_data = '0;
    bit chk_data = 0;
    bit bc;
    case (op)
      0: begin
        tgt = m_shr[addr] & ~bit_s; exp_code = 0; chk_data = 1;
        exp_data = (m_st[addr] == 2 && m_own[addr] != src && m_dirty[addr]) ? m_loc[addr] : m_mem[addr];
      end
      1: if (!(m_st[addr] == 2 && !is_own)) begin exp_code = 0; chk_data = 1; exp_data = m_mem[addr]; end
      2: exp_code = (is_own && !dirty_in) ? 0 : 1;
      3: exp_code = is_own ? 1 : 0;
      4: exp_code = (m_st[addr] == 2) ? 3 : 2;
      5: exp_code = is_own ? 0 : 1;
      default: exp_code = 1;
    endcase
    bc = pc(tgt) > LIM;
    for (int k = 0; k < 50 && req_ready !== 1'b1; k++) @(negedge clk);
    req_valid = 1; req_op = 3'(op); req_src = SW'(src); req_addr = AW'(addr);
    req_dirty = dirty_in; req_data = data_in;
    @(negedge clk);
    req_valid = 0;
    if (tgt != '0) begin
      chk(inv_valid === 1'b1, {rq, " R4 invalidation sent"}, inv_valid, 1);
      chk(inv_mask === tgt, {rq, " R4 invalidation mask"}, inv_mask, tgt);
      chk(inv_bcast === bc, {rq, " R5 broadcast flag"}, inv_bcast, bc);
      chk(req_ready === 1'b0, {rq, " R8 busy while waiting"}, req_ready, 0);
      // R7: unawaited dirty ack from the requester itself
      ack_valid = 1; ack_src = SW'(src); ack_dirty = 1; ack_data = 16'hBAD5;
      @(negedge clk);
      for (int i = 0; i < NP; i++) if (tgt[i]) begin
        ack_valid = 1; ack_src = SW'(i);
        ack_dirty = (m_st[addr] == 2 && m_own[addr] == i) ? m_dirty[addr] : 1'b0;
        ack_data  = ack_dirty ? m_loc[addr] : DW'($urandom);
        @(negedge clk);
      end
      ack_valid = 0; ack_dirty = 0;
    end else begin
      chk(inv_valid === 1'b0, {rq, " no invalidation"}, inv_valid, 0);
    end
    for (int k = 0; k < 20 && resp_valid !== 1'b1; k++) @(negedge clk);
    chk(resp_valid === 1'b1, {rq, " response present"}, resp_valid, 1);
    chk(resp_code === 2'(exp_code), {rq, " response code"}, resp_code, exp_code);
    chk(resp_dst === SW'(src), {rq, " response destination"}, resp_dst, src);
    if (chk_data && exp_code == 0)
      chk(resp_data === exp_data, {rq, " R6 response data"}, resp_data, exp_data);
    @(negedge clk);
    if (exp_code == 0) begin
      case (op)
        0: begin
          if (m_st[addr] == 2 && m_own[addr] != src && m_dirty[addr]) m_mem[addr] = m_loc[addr];
          m_st[addr] = 2; m_own[addr] = src; m_shr[addr] = bit_s;
          m_dirty[addr] = 0; m_loc[addr] = m_mem[addr];
        end
        1: begin m_shr[addr] |= bit_s; if (m_st[addr] == 0) m_st[addr] = 1; end
        2: begin m_st[addr] = 1; m_shr[addr] = bit_s; end
        3: begin m_shr[addr] &= ~bit_s; if (m_shr[addr] == '0) m_st[addr] = 0; end
        5: begin m_mem[addr] = data_in; m_dirty[addr] = 0; end
        default: ;
      endcase
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    string tags [6] = '{"R4", "R3", "R9", "R11", "R2", "R10"};
    void'($urandom(32'd2024));
    for (int a = 0; a < NA; a++) begin
      m_st[a] = 0; m_own[a] = 0; m_shr[a] = '0; m_mem[a] = '0; m_dirty[a] = 0; m_loc[a] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
    chk(resp_valid === 1'b0, "R1 no response after reset", resp_valid, 0);
    chk(inv_valid === 1'b0, "R1 no invalidation after reset", inv_valid, 0);
    for (int a = 0; a < NA; a++) xact(4, a % NP, a, "R1 check free");
    xact(1, 2, 0, "R1 fill zero");

    // directed corners
    xact(1, 0, 1, "R3 fill p0");
    xact(1, 1, 1, "R3 fill p1");
    xact(1, 2, 1, "R3 fill p2");
    xact(0, 3, 1, "R5 lock over limit");
    xact(4, 0, 1, "R2 check held");
    xact(1, 0, 1, "R3 fill refused");
    m_dirty[1] = 1; m_loc[1] = 16'hA5A5;
    xact(2, 3, 1, "R9 dirty release refused");
    xact(0, 0, 1, "R6 lock takes dirty data");
    xact(5, 1, 1, "R10 foreign flush refused");
    m_dirty[1] = 1; m_loc[1] = 16'h1234;
    xact(5, 0, 1, "R10 owner flush");
    xact(2, 0, 1, "R9 clean release");
    xact(1, 2, 1, "R10 fill sees flushed data");
    xact(0, 1, 1, "R5 lock at limit");
    xact(3, 1, 1, "R11 owner drop refused");
    xact(2, 1, 1, "R9 release");
    xact(3, 1, 1, "R11 drop");
    xact(4, 2, 1, "R2 check free");
    xact(0, 2, 1, "R4 lock sole holder");

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 5);
      int src = $urandom_range(0, NP - 1);
      int addr = $urandom_range(0, 3);
      if ($urandom_range(0, 7) == 0) begin
        // R7: stray ack while idle
        ack_valid = 1; ack_src = SW'($urandom_range(0, NP - 1)); ack_dirty = 1; ack_data = 16'hBEEF;
        @(negedge clk);
        ack_valid = 0; ack_dirty = 0;
      end
      xact(op, src, addr, {tags[op], " random R7"});
      if (op == 0 && $urandom_range(0, 1) == 1) begin
        m_dirty[addr] = 1; m_loc[addr] = DW'($urandom);
      end
    end
    finish_run();
  end
endmodule